// File: doc/BRIEF.md
# Per-Core Interrupt Acknowledge Interface

This block is one processor core's private window onto a multi-source interrupt controller. Upstream trigger and routing logic present a vector of pending sources. Software on the core configures and services those sources through a small 32-bit register port. Each source is enabled or disabled by writing its number to a dedicated register, so no read-modify-write of a bitmask is needed. A read of the acknowledge register returns the number of the highest-priority ready source and takes it into service in the same access. Service ends when the core writes that number to the completion register.

Priority is fixed: the lowest source number wins. A source that has been taken stays out of arbitration until its completion write arrives, even if its pending line is still high. The block drives a single request line to the core. It also turns one packed register write, which carries an interrupt ID and a mask of target cores, into a one-cycle inter-processor interrupt request toward the rest of the controller.

Top module: `core_irq_ack`

## Requirements
- R1: After reset, every source is disabled and idle, irq_o and ipi_req_o are low, the control register reads 0, and the acknowledge register reads 0xFFFFFFFF.
- R2: Bit 0 of the control register at offset 0x000 switches the interface on and reads back there. While it is 0, irq_o is low, an acknowledge read returns 0xFFFFFFFF and takes nothing into service, and IPI writes are dropped.
- R3: Writing a source number N to offset 0x0A0 enables source N. A number of NUM_IRQ or more changes no enable.
- R4: Writing a source number N to offset 0x0A4 disables source N, which then no longer raises irq_o or appears on an acknowledge read.
- R5: A read of offset 0x06C returns, as a zero-extended number, the lowest-numbered source that is pending, enabled and not in service, and puts that source in service from the next cycle.
- R6: When no source is ready, a read of offset 0x06C returns 0xFFFFFFFF and changes no state.
- R7: A source in service is not returned again and does not hold irq_o high until its number is written to offset 0x0B4. That write takes it out of service.
- R8: irq_o is high in the same cycle, combinationally from pend_i, exactly when the interface is on and some source is pending, enabled and not in service.
- R9: A write to offset 0x060 while the interface is on drives ipi_req_o high for exactly the next cycle. In that cycle ipi_id_o holds write bits [3:0] and ipi_mask_o holds write bits [8+NUM_CORES-1:8].
- R10: A read of any offset other than 0x000 and 0x06C returns 0. A write to any offset not named above has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_req_i | input | 1 | Register access valid this cycle |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 12 | Byte offset inside the core's 4 KiB window |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the access cycle |
| pend_i | input | NUM_IRQ | Pending levels from trigger unit and router |
| irq_o | output | 1 | Interrupt request to the core |
| ipi_req_o | output | 1 | One-cycle inter-processor interrupt request |
| ipi_id_o | output | 4 | IPI interrupt ID |
| ipi_mask_o | output | NUM_CORES | IPI target core mask |

## Verification
The assertions assume at most one register access per cycle, addresses that are word offsets inside the window, and a pend_i that holds steady around each rising edge. Under these assumptions an acknowledge and a completion never coincide, and the take-into-service and clear properties can tie each state change to a single access. The stimulus keeps to them. All inputs change on falling edges, accesses are issued one at a time by tasks, and pend_i is changed only between accesses. Read data is sampled before the rising edge that commits the access.

// File: rtl/core_irq_pkg.sv
package core_irq_pkg;
  localparam int unsigned REG_ADDR_W = 12;

  localparam logic [REG_ADDR_W-1:0] OFF_CTRL   = 12'h000;
  localparam logic [REG_ADDR_W-1:0] OFF_IPI    = 12'h060;
  localparam logic [REG_ADDR_W-1:0] OFF_CLAIM  = 12'h06C;
  localparam logic [REG_ADDR_W-1:0] OFF_EN_SET = 12'h0A0;
  localparam logic [REG_ADDR_W-1:0] OFF_EN_CLR = 12'h0A4;
  localparam logic [REG_ADDR_W-1:0] OFF_EOI    = 12'h0B4;

  localparam logic [31:0] NONE_ID = 32'hFFFF_FFFF;

  localparam int unsigned IPI_ID_W   = 4;
  localparam int unsigned IPI_MASK_LSB = 8;

  typedef struct packed {
    logic ctrl_wr;
    logic ctrl_rd;
    logic ipi_wr;
    logic claim_rd;
    logic en_set;
    logic en_clr;
    logic eoi_wr;
  } reg_stb_t;
endpackage

// File: rtl/cia_reg_decode.sv
module cia_reg_decode
  import core_irq_pkg::*;
(
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  output reg_stb_t              stb_o
);
  logic wr, rd;
  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  always_comb begin
    stb_o          = '0;
    stb_o.ctrl_wr  = wr && (addr_i == OFF_CTRL);
    stb_o.ctrl_rd  = rd && (addr_i == OFF_CTRL);
    stb_o.ipi_wr   = wr && (addr_i == OFF_IPI);
    stb_o.claim_rd = rd && (addr_i == OFF_CLAIM);
    stb_o.en_set   = wr && (addr_i == OFF_EN_SET);
    stb_o.en_clr   = wr && (addr_i == OFF_EN_CLR);
    stb_o.eoi_wr   = wr && (addr_i == OFF_EOI);
  end
endmodule

// File: rtl/cia_vec_state.sv
module cia_vec_state #(
  parameter int unsigned NUM_IRQ = 32,
  localparam int unsigned ID_W = $clog2(NUM_IRQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_set_i,
  input  logic               en_clr_i,
  input  logic               eoi_i,
  input  logic [31:0]        wr_id_i,
  input  logic               claim_i,
  input  logic [ID_W-1:0]    claim_id_i,
  output logic [NUM_IRQ-1:0] en_o,
  output logic [NUM_IRQ-1:0] act_o
);
  logic [NUM_IRQ-1:0] en_q, act_q;
  logic               wr_ok;
  logic [ID_W-1:0]    wr_idx;

  // out-of-range numbers must not alias onto low IDs
  assign wr_ok  = wr_id_i < 32'(NUM_IRQ);
  assign wr_idx = wr_id_i[ID_W-1:0];

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
    logic hit;
    assign hit = wr_ok && (wr_idx == ID_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[i]  <= 1'b0;
        act_q[i] <= 1'b0;
      end else begin
        if (en_set_i && hit)      en_q[i] <= 1'b1;
        else if (en_clr_i && hit) en_q[i] <= 1'b0;
        if (claim_i && claim_id_i == ID_W'(i)) act_q[i] <= 1'b1;
        else if (eoi_i && hit)                 act_q[i] <= 1'b0;
      end
    end

    assert_eoi_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eoi_i && wr_ok && wr_idx == ID_W'(i) && !claim_i) |=> !act_q[i]);
    assert_enable_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_set_i && wr_ok && wr_idx == ID_W'(i)) |=> en_q[i]);
  end

  assert_take_needs_claim_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((act_q & ~$past(act_q)) != '0) |-> $past(claim_i));
  assert_take_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(act_q & ~$past(act_q)));

  assign en_o  = en_q;
  assign act_o = act_q;
endmodule

// File: rtl/cia_prio_pick.sv
module cia_prio_pick #(
  parameter int unsigned N = 32,
  localparam int unsigned ID_W = $clog2(N)
) (
  input  logic [N-1:0]    vec_i,
  output logic            found_o,
  output logic [ID_W-1:0] id_o
);
  // descending scan: the last hit is the lowest index
  always_comb begin
    found_o = 1'b0;
    id_o    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        id_o    = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/cia_ipi_gen.sv
module cia_ipi_gen
  import core_irq_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fire_i,
  input  logic [IPI_ID_W-1:0]  id_i,
  input  logic [NUM_CORES-1:0] mask_i,
  output logic                 req_o,
  output logic [IPI_ID_W-1:0]  id_o,
  output logic [NUM_CORES-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o  <= 1'b0;
      id_o   <= '0;
      mask_o <= '0;
    end else begin
      req_o <= fire_i;
      if (fire_i) begin
        id_o   <= id_i;
        mask_o <= mask_i;
      end
    end
  end
endmodule

// File: rtl/core_irq_ack.sv
module core_irq_ack
  import core_irq_pkg::*;
#(
  parameter int unsigned NUM_IRQ   = 32,
  parameter int unsigned NUM_CORES = 4,
  localparam int unsigned ID_W     = $clog2(NUM_IRQ)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_req_i,
  input  logic                  reg_we_i,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]           reg_wdata_i,
  output logic [31:0]           reg_rdata_o,
  input  logic [NUM_IRQ-1:0]    pend_i,
  output logic                  irq_o,
  output logic                  ipi_req_o,
  output logic [IPI_ID_W-1:0]   ipi_id_o,
  output logic [NUM_CORES-1:0]  ipi_mask_o
);
  reg_stb_t           stb;
  logic               ctrl_en_q;
  logic [NUM_IRQ-1:0] en_vec, act_vec, ready;
  logic               found;
  logic [ID_W-1:0]    pick_id;
  logic               claim_take;

  cia_reg_decode u_dec (
    .req_i  (reg_req_i),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .stb_o  (stb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ctrl_en_q <= 1'b0;
    else if (stb.ctrl_wr) ctrl_en_q <= reg_wdata_i[0];
  end

  assign ready = ctrl_en_q ? (pend_i & en_vec & ~act_vec) : '0;

  cia_prio_pick #(.N(NUM_IRQ)) u_pick (
    .vec_i   (ready),
    .found_o (found),
    .id_o    (pick_id)
  );

  assign claim_take = stb.claim_rd & found;

  cia_vec_state #(.NUM_IRQ(NUM_IRQ)) u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_set_i   (stb.en_set),
    .en_clr_i   (stb.en_clr),
    .eoi_i      (stb.eoi_wr),
    .wr_id_i    (reg_wdata_i),
    .claim_i    (claim_take),
    .claim_id_i (pick_id),
    .en_o       (en_vec),
    .act_o      (act_vec)
  );

  cia_ipi_gen #(.NUM_CORES(NUM_CORES)) u_ipi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (stb.ipi_wr & ctrl_en_q),
    .id_i   (reg_wdata_i[IPI_ID_W-1:0]),
    .mask_i (reg_wdata_i[IPI_MASK_LSB +: NUM_CORES]),
    .req_o  (ipi_req_o),
    .id_o   (ipi_id_o),
    .mask_o (ipi_mask_o)
  );

  assign irq_o = found;

  always_comb begin
    reg_rdata_o = '0;
    if (stb.claim_rd)     reg_rdata_o = found ? 32'(pick_id) : NONE_ID;
    else if (stb.ctrl_rd) reg_rdata_o = {31'b0, ctrl_en_q};
  end

  logic [NUM_IRQ-1:0] below_pick;
  assign below_pick = (NUM_IRQ'(1) << pick_id) - NUM_IRQ'(1);

  assert_pick_lowest_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found |-> (pend_i[pick_id] && en_vec[pick_id] && !act_vec[pick_id]
               && ((pend_i & en_vec & ~act_vec & below_pick) == '0)));
  assert_off_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_en_q |-> (!irq_o && !claim_take));
  assert_none_reads_ones_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb.claim_rd && !irq_o) |-> (reg_rdata_o == NONE_ID));
  assert_ipi_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ipi_req_o |-> ($past(ctrl_en_q) && $past(reg_req_i && reg_we_i)));
endmodule

// File: tb/core_irq_ack_tb_top.sv
`timescale 1ns/1ps
module core_irq_ack_tb_top;
  localparam int unsigned NI = 16;
  localparam int unsigned NC = 4;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0, rdata;
  logic [NI-1:0] pend = '0;
  logic          irq, ipi_req;
  logic [3:0]    ipi_id;
  logic [NC-1:0] ipi_mask;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  core_irq_ack #(.NUM_IRQ(NI), .NUM_CORES(NC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_req_i(req), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .pend_i(pend), .irq_o(irq), .ipi_req_o(ipi_req), .ipi_id_o(ipi_id),
    .ipi_mask_o(ipi_mask)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(posedge clk);
    @(negedge clk); req = 1'b0;
  endtask

  function automatic logic [31:0] lowest(input logic [NI-1:0] v);
    for (int i = 0; i < NI; i++) if (v[i]) return 32'(i);
    return ONES;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [NI-1:0] en_m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1 chk("R1 irq", 32'(irq), 0);
    chk("R1 ipi_req", 32'(ipi_req), 0);
    rd(12'h000, d); chk("R1 ctrl", d, 0);
    rd(12'h06C, d); chk("R1 claim", d, ONES);

    // R2 interface off blocks everything
    wr(12'h0A0, 32'd3); pend = 16'h0008;
    #1 chk("R2 irq while off", 32'(irq), 0);
    rd(12'h06C, d); chk("R2 claim while off", d, ONES);
    wr(12'h060, 32'h0000_0F05);
    chk("R2 ipi dropped", 32'(ipi_req), 0);
    wr(12'h000, 32'd1);
    rd(12'h000, d); chk("R2 ctrl readback", d, 1);
    #1 chk("R2 irq after on", 32'(irq), 1);
    rd(12'h06C, d); chk("R2 nothing taken while off", d, 3);
    wr(12'h0B4, 32'd3); wr(12'h0A4, 32'd3); pend = '0;

    // R6 pending but nothing enabled
    pend = '1;
    #1 chk("R6 irq none enabled", 32'(irq), 0);
    rd(12'h06C, d); chk("R6 claim none", d, ONES);

    // per-source sweep: R3 R4 R5 R7 R8
    for (int id = 0; id < NI; id++) begin
      pend = NI'(1) << id;
      wr(12'h0A0, 32'(id));
      #1 chk("R8 irq raised", 32'(irq), 1);
      rd(12'h06C, d); chk("R5 R3 claim id", d, 32'(id));
      #1 chk("R7 irq dropped while active", 32'(irq), 0);
      rd(12'h06C, d); chk("R7 not re-presented", d, ONES);
      wr(12'h0B4, 32'(id));
      #1 chk("R7 irq after eoi", 32'(irq), 1);
      wr(12'h0A4, 32'(id));
      #1 chk("R4 irq after disable", 32'(irq), 0);
      rd(12'h06C, d); chk("R4 claim after disable", d, ONES);
    end

    // R3 out-of-range enable, R10 unmapped write
    pend = '1;
    wr(12'h0A0, 32'(NI));
    wr(12'h0A0, 32'h0000_0100);
    wr(12'h0A8, 32'd2);
    #1 chk("R3 out of range ignored", 32'(irq), 0);
    rd(12'h06C, d); chk("R3 claim after bad id", d, ONES);
    rd(12'h0A0, d); chk("R10 read unmapped", d, 0);

    // R5 R8 pattern sweep over low 8 sources with fixed enable set
    en_m = 16'h00B7;
    for (int i = 0; i < 8; i++) if (en_m[i]) wr(12'h0A0, 32'(i));
    for (int p = 0; p < 256; p++) begin
      logic [31:0] e;
      pend = NI'(p);
      e = lowest(NI'(p) & en_m);
      #1 chk("R8 pattern irq", 32'(irq), 32'(e != ONES));
      rd(12'h06C, d); chk("R5 pattern claim", d, e);
      if (e != ONES) wr(12'h0B4, e);
    end

    // R5 R7 successive claims in ascending order
    pend = 16'h00FF;
    for (int i = 0; i < 8; i++) if (en_m[i]) begin
      rd(12'h06C, d); chk("R5 ordered claim", d, 32'(i));
    end
    rd(12'h06C, d); chk("R7 all active", d, ONES);
    #1 chk("R7 irq low all active", 32'(irq), 0);
    wr(12'h0B4, 32'd5);
    rd(12'h06C, d); chk("R7 reclaim after eoi", d, 5);
    for (int i = 0; i < 8; i++) wr(12'h0B4, 32'(i));

    // R9 IPI encoding
    for (int id = 0; id < 16; id++) begin
      logic [NC-1:0] m;
      m = NC'(id * 5 + 1);
      wr(12'h060, (32'(m) << 8) | 32'(id) | 32'hFFFF_0000);
      chk("R9 ipi req", 32'(ipi_req), 1);
      chk("R9 ipi id", 32'(ipi_id), 32'(id));
      chk("R9 ipi mask", 32'(ipi_mask), 32'(m));
      @(negedge clk);
      chk("R9 ipi one cycle", 32'(ipi_req), 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule